// File: doc/BRIEF.md
# Lane-Pattern Deduplication Stage for a 16-Lane SIMT Pipeline

This stage sits between instruction decode and operand read, alongside the execution-mask stage. For each architectural vector register it records whether the 16 lanes all hold one value (uniform), or hold a base plus the lane number times a stride (affine), or hold anything else (unknown). Registers that are uniform or affine are also kept in compressed form in a small scalar store, as a base and a stride.

When an instruction issues, the stage looks up the tags of both sources. For a small set of integer operations it computes the destination tag and the compressed result directly from the base/stride pairs. These operations are thread-index move, immediate move, add, subtract, and multiply by a uniform. One cycle later it passes the register IDs and their tags on to operand read. With them it sends enables for the vector register file read, the SIMD lanes and the vector register file write. When the result is deduplicated, all three enables are low, so that the wide storage and datapath can be clock-gated.

A separate expansion port rebuilds any single lane of a deduplicated register on request. It returns base + lane·stride. All arithmetic is 32-bit two's complement with wraparound, so an expanded lane matches a per-lane computation bit for bit.

Top module: `dedup_stage`

## Requirements
- R1: Reset clears every register tag to unknown. Straight after reset, out_valid and exp_valid are 0, and expanding any register gives exp_dedup=0 and exp_data=0.
- R2: Opcode 0 (thread-index move) with a full mask makes the destination affine (tag code 2) with base 0 and stride 1. Lane i then expands to i.
- R3: Opcode 1 (immediate move) with a full mask makes the destination uniform (tag code 1) with base equal to the immediate and stride 0.
- R4: Opcode 2 (add) and opcode 3 (subtract) on two deduplicated sources add or subtract both bases and strides. The result is tagged uniform when the resulting stride is 0, and affine otherwise.
- R5: Opcode 4 (multiply) with one uniform source and one deduplicated source scales the other source's base and stride by the uniform value. Affine times affine gives unknown. Any source tagged unknown gives unknown.
- R6: Opcode 5 (gather load) always gives an unknown destination, even when its address register is affine.
- R7: An instruction issued with any exec-mask bit clear gives an unknown destination and raises the vector write enable.
- R8: The result is deduplicated exactly when vrf read, SIMD and vrf write enables are all 0. For any unknown result, all three are 1.
- R9: One cycle after issue, the stage reports the destination ID and tag, the compressed value, and both source IDs with the tags they held at issue. This includes a source written by the instruction directly before it.
- R10: An expansion request returns, one cycle later, exp_dedup=1 and base + lane·stride for a deduplicated register. For an unknown register it returns exp_dedup=0 and data 0. An unknown write to a register that was deduplicated turns its expansion off.
- R11: Base and stride arithmetic wraps modulo 2^32, so expanded lanes equal the per-lane 32-bit results even when they overflow.
- R12: Opcodes 6 and 7 (other operations) always give an unknown destination with all enables high.

Tag codes are 0 = unknown, 1 = uniform and 2 = affine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An instruction issues this cycle |
| issue_op | input | 3 | Opcode (0 tid move, 1 imm move, 2 add, 3 sub, 4 mul, 5 gather, 6/7 other) |
| issue_dst | input | 4 | Destination register ID |
| issue_src_a | input | 4 | First source register ID |
| issue_src_b | input | 4 | Second source register ID |
| issue_imm | input | 32 | Immediate for opcode 1 |
| issue_mask | input | 16 | Per-lane execution mask |
| out_valid | output | 1 | Forwarded instruction valid |
| out_dst | output | 4 | Destination register ID |
| out_dst_tag | output | 2 | Destination tag |
| out_base | output | 32 | Compressed result base (lane 0) |
| out_stride | output | 32 | Compressed result stride |
| out_src_a | output | 4 | First source ID |
| out_src_a_tag | output | 2 | First source tag at issue |
| out_src_b | output | 4 | Second source ID |
| out_src_b_tag | output | 2 | Second source tag at issue |
| out_vrf_rd_en | output | 1 | Vector register file read enable |
| out_simd_en | output | 1 | SIMD lane enable |
| out_vrf_wr_en | output | 1 | Vector register file write enable |
| exp_req | input | 1 | Expansion request |
| exp_reg | input | 4 | Register to expand |
| exp_lane | input | 4 | Lane to expand |
| exp_valid | output | 1 | Expansion result valid |
| exp_dedup | output | 1 | Expanded register was deduplicated |
| exp_data | output | 32 | Expanded lane value |

## Verification
The bench keeps a full 16-lane value for every register and computes each operation lane by lane. It then compares the design's base, stride and expanded lanes against those vectors. A design that forgot to scale the stride in a multiply, or that saturated instead of wrapping, would show wrong high lanes near 2^31. A design that tagged a zero-stride difference as affine, or that promoted affine times affine, would report the wrong tag and leave the gates open or shut. The bench also issues a dependent instruction directly after its producer, so a stage that read a stale tag would forward unknown. It writes unknown under a partial mask and over a previously affine register, so a design that kept the old compressed value would still answer expansion requests.

// File: rtl/dedup_pkg.sv
package dedup_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        TAG_K = 2'd0,
        TAG_U = 2'd1,
        TAG_A = 2'd2
    } tag_e;

    typedef enum logic [2:0] {
        OP_TID    = 3'd0,
        OP_IMM    = 3'd1,
        OP_ADD    = 3'd2,
        OP_SUB    = 3'd3,
        OP_MUL    = 3'd4,
        OP_GATHER = 3'd5,
        OP_OTH6   = 3'd6,
        OP_OTH7   = 3'd7
    } op_e;

    typedef struct packed {
        tag_e            tag;
        logic [XLEN-1:0] base;
        logic [XLEN-1:0] stride;
    } compact_t;

    localparam compact_t COMPACT_NONE = '{tag: TAG_K, base: '0, stride: '0};

    function automatic logic is_dedup(input tag_e t);
        return t != TAG_K;
    endfunction

    function automatic tag_e shape_of(input logic [XLEN-1:0] stride);
        return (stride == '0) ? TAG_U : TAG_A;
    endfunction

endpackage

// File: rtl/dedup_tag_file.sv
module dedup_tag_file
    import dedup_pkg::*;
#(
    parameter int NREGS = 16,
    localparam int RID_W = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RID_W-1:0] wr_id,
    input  compact_t         wr_val,
    input  logic [RID_W-1:0] rd_a_id,
    input  logic [RID_W-1:0] rd_b_id,
    input  logic [RID_W-1:0] rd_x_id,
    output compact_t         rd_a,
    output compact_t         rd_b,
    output compact_t         rd_x
);

    compact_t entries [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[g] <= COMPACT_NONE;
            end else if (wr_en && (wr_id == RID_W'(g))) begin
                entries[g] <= wr_val;
            end
        end
    end

    assign rd_a = entries[rd_a_id];
    assign rd_b = entries[rd_b_id];
    assign rd_x = entries[rd_x_id];

endmodule

// File: rtl/dedup_alu.sv
module dedup_alu
    import dedup_pkg::*;
(
    input  op_e             op,
    input  logic            full_mask,
    input  compact_t        src_a,
    input  compact_t        src_b,
    input  logic [XLEN-1:0] imm,
    output compact_t        result
);

    logic            ok;
    logic [XLEN-1:0] r_base;
    logic [XLEN-1:0] r_stride;
    logic            a_d;
    logic            b_d;

    always_comb begin
        a_d      = is_dedup(src_a.tag);
        b_d      = is_dedup(src_b.tag);
        ok       = 1'b0;
        r_base   = '0;
        r_stride = '0;
        unique case (op)
            OP_TID: begin
                ok       = 1'b1;
                r_base   = '0;
                r_stride = XLEN'(1);
            end
            OP_IMM: begin
                ok       = 1'b1;
                r_base   = imm;
                r_stride = '0;
            end
            OP_ADD: begin
                ok       = a_d && b_d;
                r_base   = src_a.base + src_b.base;
                r_stride = src_a.stride + src_b.stride;
            end
            OP_SUB: begin
                ok       = a_d && b_d;
                r_base   = src_a.base - src_b.base;
                r_stride = src_a.stride - src_b.stride;
            end
            OP_MUL: begin
                if (src_a.tag == TAG_U && b_d) begin
                    ok       = 1'b1;
                    r_base   = src_b.base * src_a.base;
                    r_stride = src_b.stride * src_a.base;
                end else if (src_b.tag == TAG_U && a_d) begin
                    ok       = 1'b1;
                    r_base   = src_a.base * src_b.base;
                    r_stride = src_a.stride * src_b.base;
                end
            end
            default: ok = 1'b0;
        endcase

        if (ok && full_mask) begin
            result.tag    = shape_of(r_stride);
            result.base   = r_base;
            result.stride = r_stride;
        end else begin
            result = COMPACT_NONE;
        end
    end

endmodule

// File: rtl/dedup_expand.sv
module dedup_expand
    import dedup_pkg::*;
#(
    parameter int LANES = 16,
    localparam int LID_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [LID_W-1:0] lane,
    input  compact_t         entry,
    output logic             valid,
    output logic             dedup,
    output logic [XLEN-1:0]  data
);

    logic [XLEN-1:0] lane_val;

    always_comb begin
        lane_val = entry.base + (XLEN'(lane) * entry.stride);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            dedup <= 1'b0;
            data  <= '0;
        end else begin
            valid <= req;
            if (req) begin
                dedup <= is_dedup(entry.tag);
                data  <= is_dedup(entry.tag) ? lane_val : '0;
            end
        end
    end

endmodule

// File: rtl/dedup_stage.sv
module dedup_stage
    import dedup_pkg::*;
#(
    parameter int LANES = 16,
    parameter int NREGS = 16,
    localparam int RID_W = $clog2(NREGS),
    localparam int LID_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_valid,
    input  logic [2:0]       issue_op,
    input  logic [RID_W-1:0] issue_dst,
    input  logic [RID_W-1:0] issue_src_a,
    input  logic [RID_W-1:0] issue_src_b,
    input  logic [31:0]      issue_imm,
    input  logic [LANES-1:0] issue_mask,
    output logic             out_valid,
    output logic [RID_W-1:0] out_dst,
    output logic [1:0]       out_dst_tag,
    output logic [31:0]      out_base,
    output logic [31:0]      out_stride,
    output logic [RID_W-1:0] out_src_a,
    output logic [1:0]       out_src_a_tag,
    output logic [RID_W-1:0] out_src_b,
    output logic [1:0]       out_src_b_tag,
    output logic             out_vrf_rd_en,
    output logic             out_simd_en,
    output logic             out_vrf_wr_en,
    input  logic             exp_req,
    input  logic [RID_W-1:0] exp_reg,
    input  logic [LID_W-1:0] exp_lane,
    output logic             exp_valid,
    output logic             exp_dedup,
    output logic [31:0]      exp_data
);

    compact_t src_a_val;
    compact_t src_b_val;
    compact_t exp_val;
    compact_t res_val;
    logic     full_mask;
    logic     gated;

    assign full_mask = &issue_mask;

    dedup_tag_file #(.NREGS(NREGS)) u_tags (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (issue_valid),
        .wr_id   (issue_dst),
        .wr_val  (res_val),
        .rd_a_id (issue_src_a),
        .rd_b_id (issue_src_b),
        .rd_x_id (exp_reg),
        .rd_a    (src_a_val),
        .rd_b    (src_b_val),
        .rd_x    (exp_val)
    );

    dedup_alu u_alu (
        .op        (op_e'(issue_op)),
        .full_mask (full_mask),
        .src_a     (src_a_val),
        .src_b     (src_b_val),
        .imm       (issue_imm),
        .result    (res_val)
    );

    dedup_expand #(.LANES(LANES)) u_expand (
        .clk   (clk),
        .rst   (rst),
        .req   (exp_req),
        .lane  (exp_lane),
        .entry (exp_val),
        .valid (exp_valid),
        .dedup (exp_dedup),
        .data  (exp_data)
    );

    assign gated = is_dedup(res_val.tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            out_dst       <= '0;
            out_dst_tag   <= TAG_K;
            out_base      <= '0;
            out_stride    <= '0;
            out_src_a     <= '0;
            out_src_a_tag <= TAG_K;
            out_src_b     <= '0;
            out_src_b_tag <= TAG_K;
            out_vrf_rd_en <= 1'b0;
            out_simd_en   <= 1'b0;
            out_vrf_wr_en <= 1'b0;
        end else begin
            out_valid <= issue_valid;
            if (issue_valid) begin
                out_dst       <= issue_dst;
                out_dst_tag   <= res_val.tag;
                out_base      <= res_val.base;
                out_stride    <= res_val.stride;
                out_src_a     <= issue_src_a;
                out_src_a_tag <= src_a_val.tag;
                out_src_b     <= issue_src_b;
                out_src_b_tag <= src_b_val.tag;
                out_vrf_rd_en <= !gated;
                out_simd_en   <= !gated;
                out_vrf_wr_en <= !gated;
            end else begin
                out_vrf_rd_en <= 1'b0;
                out_simd_en   <= 1'b0;
                out_vrf_wr_en <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dedup_stage_chk.sv
module dedup_stage_chk #(
    parameter int LANES = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             issue_valid,
    input logic [2:0]       issue_op,
    input logic [LANES-1:0] issue_mask,
    input logic             out_valid,
    input logic [1:0]       out_dst_tag,
    input logic [31:0]      out_stride,
    input logic [31:0]      out_base,
    input logic             out_vrf_rd_en,
    input logic             out_simd_en,
    input logic             out_vrf_wr_en,
    input logic             exp_valid,
    input logic             exp_dedup,
    input logic [31:0]      exp_data
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!out_valid && !exp_valid));

    assert_tid_affine_R2: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 3'd0 && (&issue_mask))
        |=> (out_dst_tag == 2'd2 && out_base == 32'd0 && out_stride == 32'd1));

    assert_shape_matches_stride_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dst_tag != 2'd0) |-> ((out_dst_tag == 2'd1) == (out_stride == 32'd0)));

    assert_gather_unknown_R6: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op == 3'd5) |=> (out_dst_tag == 2'd0));

    assert_partial_mask_unknown_R7: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && !(&issue_mask)) |=> (out_dst_tag == 2'd0 && out_vrf_wr_en));

    assert_gates_follow_tag_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_dst_tag == 2'd0) == (out_vrf_rd_en && out_simd_en && out_vrf_wr_en)));

    assert_other_unknown_R12: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_op[2:1] == 2'b11) |=> (out_dst_tag == 2'd0));

    assert_expand_unknown_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && !exp_dedup) |-> (exp_data == 32'd0));

endmodule

bind dedup_stage dedup_stage_chk #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .issue_valid   (issue_valid),
    .issue_op      (issue_op),
    .issue_mask    (issue_mask),
    .out_valid     (out_valid),
    .out_dst_tag   (out_dst_tag),
    .out_stride    (out_stride),
    .out_base      (out_base),
    .out_vrf_rd_en (out_vrf_rd_en),
    .out_simd_en   (out_simd_en),
    .out_vrf_wr_en (out_vrf_wr_en),
    .exp_valid     (exp_valid),
    .exp_dedup     (exp_dedup),
    .exp_data      (exp_data)
);

// File: tb/dedup_stage_bench.sv
module dedup_stage_bench;

    localparam int LANES = 16;
    localparam int NREGS = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue_valid = 1'b0;
    logic [2:0]  issue_op = '0;
    logic [3:0]  issue_dst = '0, issue_src_a = '0, issue_src_b = '0;
    logic [31:0] issue_imm = '0;
    logic [15:0] issue_mask = '1;
    logic        exp_req = 1'b0;
    logic [3:0]  exp_reg = '0, exp_lane = '0;

    logic        out_valid, out_vrf_rd_en, out_simd_en, out_vrf_wr_en;
    logic [3:0]  out_dst, out_src_a, out_src_b;
    logic [1:0]  out_dst_tag, out_src_a_tag, out_src_b_tag;
    logic [31:0] out_base, out_stride;
    logic        exp_valid, exp_dedup;
    logic [31:0] exp_data;

    always #5 clk = ~clk;

    dedup_stage u_dedup_stage (
        .clk(clk), .rst(rst),
        .issue_valid(issue_valid), .issue_op(issue_op), .issue_dst(issue_dst),
        .issue_src_a(issue_src_a), .issue_src_b(issue_src_b), .issue_imm(issue_imm),
        .issue_mask(issue_mask),
        .out_valid(out_valid), .out_dst(out_dst), .out_dst_tag(out_dst_tag),
        .out_base(out_base), .out_stride(out_stride),
        .out_src_a(out_src_a), .out_src_a_tag(out_src_a_tag),
        .out_src_b(out_src_b), .out_src_b_tag(out_src_b_tag),
        .out_vrf_rd_en(out_vrf_rd_en), .out_simd_en(out_simd_en), .out_vrf_wr_en(out_vrf_wr_en),
        .exp_req(exp_req), .exp_reg(exp_reg), .exp_lane(exp_lane),
        .exp_valid(exp_valid), .exp_dedup(exp_dedup), .exp_data(exp_data)
    );

    int checks = 0;
    int errors = 0;

    // bench model: full per-lane values and rule-based tags (0 K, 1 U, 2 A)
    logic [31:0] mvec [NREGS][LANES];
    int          mtag [NREGS];

    typedef struct {
        string       req;
        logic [3:0]  dst, sa, sb;
        int          dtag, atag, btag;
        logic [31:0] base, stride;
    } out_item_t;

    typedef struct {
        string       req;
        logic        dedup;
        logic [31:0] data;
    } exp_item_t;

    out_item_t oq[$];
    exp_item_t eq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic issue(input string req, input int op, input int d, input int a,
                         input int b, input logic [31:0] imm, input logic [15:0] mask);
        logic [31:0] res [LANES];
        logic        rule;
        logic        all_eq;
        out_item_t   it;
        int          ta, tb;
        ta = mtag[a];
        tb = mtag[b];
        for (int l = 0; l < LANES; l++) begin
            case (op)
                0: res[l] = 32'(l);
                1: res[l] = imm;
                2: res[l] = mvec[a][l] + mvec[b][l];
                3: res[l] = mvec[a][l] - mvec[b][l];
                4: res[l] = mvec[a][l] * mvec[b][l];
                5: res[l] = 32'(l * l + a + 5);
                default: res[l] = mvec[a][l] ^ mvec[b][l] ^ 32'h55;
            endcase
        end
        case (op)
            0, 1:    rule = 1'b1;
            2, 3:    rule = (ta != 0) && (tb != 0);
            4:       rule = (ta == 1 && tb != 0) || (tb == 1 && ta != 0);
            default: rule = 1'b0;
        endcase
        rule = rule && (mask == 16'hFFFF);
        for (int l = 0; l < LANES; l++)
            if (mask[l]) mvec[d][l] = res[l];
        all_eq = 1'b1;
        for (int l = 1; l < LANES; l++)
            if (mvec[d][l] != mvec[d][0]) all_eq = 1'b0;
        it.req    = req;
        it.dst    = 4'(d);
        it.sa     = 4'(a);
        it.sb     = 4'(b);
        it.atag   = ta;
        it.btag   = tb;
        it.dtag   = rule ? (all_eq ? 1 : 2) : 0;
        it.base   = mvec[d][0];
        it.stride = mvec[d][1] - mvec[d][0];
        mtag[d]   = it.dtag;
        @(negedge clk);
        issue_valid = 1'b1;
        issue_op    = 3'(op);
        issue_dst   = 4'(d);
        issue_src_a = 4'(a);
        issue_src_b = 4'(b);
        issue_imm   = imm;
        issue_mask  = mask;
        exp_req     = 1'b0;
        oq.push_back(it);
    endtask

    task automatic expand(input string req, input int r, input int lane);
        exp_item_t it;
        it.req   = req;
        it.dedup = (mtag[r] != 0);
        it.data  = (mtag[r] != 0) ? mvec[r][lane] : 32'd0;
        @(negedge clk);
        issue_valid = 1'b0;
        exp_req     = 1'b1;
        exp_reg     = 4'(r);
        exp_lane    = 4'(lane);
        eq.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            issue_valid = 1'b0;
            exp_req     = 1'b0;
        end
    endtask

    // monitor: compares results against the scoreboard as they appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (oq.size() == 0) begin
                    check(1'b0, "R9", "unexpected out_valid", 1, 0);
                end else begin
                    out_item_t e;
                    bit gate;
                    e = oq.pop_front();
                    check(out_dst == e.dst, e.req, "dst id", out_dst, e.dst);
                    check(out_dst_tag == 2'(e.dtag), e.req, "dst tag", out_dst_tag, e.dtag);
                    check(out_src_a == e.sa && out_src_a_tag == 2'(e.atag), "R9", "src a id/tag",
                          {out_src_a, out_src_a_tag}, {e.sa, 2'(e.atag)});
                    check(out_src_b == e.sb && out_src_b_tag == 2'(e.btag), "R9", "src b id/tag",
                          {out_src_b, out_src_b_tag}, {e.sb, 2'(e.btag)});
                    gate = (e.dtag == 0);
                    check(out_vrf_rd_en == gate && out_simd_en == gate && out_vrf_wr_en == gate,
                          "R8", "enables", {out_vrf_rd_en, out_simd_en, out_vrf_wr_en}, {gate, gate, gate});
                    if (e.dtag != 0) begin
                        check(out_base == e.base, e.req, "base", out_base, e.base);
                        check(out_stride == e.stride, e.req, "stride", out_stride, e.stride);
                    end
                end
            end
            if (!rst && exp_valid) begin
                if (eq.size() == 0) begin
                    check(1'b0, "R10", "unexpected exp_valid", 1, 0);
                end else begin
                    exp_item_t x;
                    x = eq.pop_front();
                    check(exp_dedup == x.dedup, x.req, "exp_dedup", exp_dedup, x.dedup);
                    check(exp_data == x.data, x.req, "exp_data", exp_data, x.data);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREGS; r++) begin
            mtag[r] = 0;
            for (int l = 0; l < LANES; l++) mvec[r][l] = 32'hDEAD_0000 + 32'(r * 16 + l);
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet outputs after reset, every tag unknown
        check(out_valid == 1'b0 && exp_valid == 1'b0, "R1", "outputs after reset",
              {out_valid, exp_valid}, 0);
        expand("R1", 3, 4);
        expand("R1", 15, 0);
        // R2: thread index
        issue("R2", 0, 1, 0, 0, 32'd0, 16'hFFFF);
        idle(1);
        expand("R2", 1, 5);
        expand("R2", 1, 15);
        // R3: immediate
        issue("R3", 1, 2, 0, 0, 32'd7, 16'hFFFF);
        idle(1);
        expand("R3", 2, 9);
        // R4: add/sub, zero-stride difference becomes uniform
        issue("R4", 2, 3, 1, 2, 32'd0, 16'hFFFF);
        issue("R4", 3, 4, 2, 1, 32'd0, 16'hFFFF);
        issue("R4", 3, 5, 1, 1, 32'd0, 16'hFFFF);
        idle(1);
        expand("R4", 4, 12);
        expand("R4", 5, 7);
        // R5: multiply rules
        issue("R5", 4, 6, 1, 2, 32'd0, 16'hFFFF);
        issue("R5", 4, 7, 1, 1, 32'd0, 16'hFFFF);
        idle(1);
        expand("R5", 6, 11);
        // R6: gather at an affine address, then uniform times unknown
        issue("R6", 5, 8, 1, 1, 32'd0, 16'hFFFF);
        issue("R5", 4, 9, 2, 8, 32'd0, 16'hFFFF);
        // R7: partial mask on an otherwise dedupable add
        issue("R7", 2, 10, 1, 2, 32'd0, 16'hFF7F);
        // R12: other opcodes
        issue("R12", 6, 11, 1, 2, 32'd0, 16'hFFFF);
        issue("R12", 7, 11, 2, 2, 32'd0, 16'hFFFF);
        idle(1);
        expand("R7", 10, 3);
        // R11: wraparound past 2^31 and in a scaled product
        issue("R11", 1, 12, 0, 0, 32'h7FFF_FFF8, 16'hFFFF);
        issue("R11", 2, 13, 12, 1, 32'd0, 16'hFFFF);
        issue("R11", 4, 14, 13, 12, 32'd0, 16'hFFFF);
        idle(1);
        expand("R11", 13, 15);
        expand("R11", 14, 9);
        expand("R11", 14, 15);
        // R9: dependent instruction right after its producer
        issue("R9", 2, 15, 3, 6, 32'd0, 16'hFFFF);
        issue("R9", 3, 0, 15, 3, 32'd0, 16'hFFFF);
        idle(1);
        expand("R9", 0, 13);
        // R10: unknown write over an affine register disables expansion
        issue("R10", 5, 3, 1, 1, 32'd0, 16'hFFFF);
        idle(1);
        expand("R10", 3, 2);
        expand("R10", 6, 0);
        idle(3);
        check(oq.size() == 0 && eq.size() == 0, "R9", "scoreboard drained",
              oq.size() + eq.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule